// File: doc/BRIEF.md
# Fractional Multiply-Accumulate Unit

This block multiplies two signed fractional operands, scales the product back to the operand's fixed-point format by an arithmetic right shift, and adds the result to an accumulator value with wraparound. Each operand is not a full source word but one half of it, picked by a two-bit selection code, so a datapath can combine any pairing of low and high halves from two packed source registers.

Three forms share the datapath. In the narrow form, a halfword from each source gives a product that is added to a 32-bit accumulator. In the wide form, a 32-bit half from each source gives a product that is added to a 64-bit accumulator. In the packed form, each 32-bit lane of a 64-bit accumulator takes its own pair of halfwords from the matching 32-bit lane of the sources. An optional rounding step adds half of one output LSB before the shift. No result is ever clamped and no saturation is flagged. A valid strobe launches an operation, and the registered result appears one clock later.

Top module: `qmac_unit`

## Requirements
- R1: While rst_n is low, out_valid is 0 and result is all zeros.
- R2: A cycle with in_valid=1 gives out_valid=1 and the new result after the next rising edge. A cycle with in_valid=0 gives out_valid=0 at the next edge and leaves result unchanged, whatever the other inputs are.
- R3: sel[1] picks the rs1 operand half and sel[0] picks the rs2 operand half, where 0 means the low half and 1 means the high half. Code 00 is low/low, 01 is rs1 low with rs2 high, 11 is high/high, and 10 is rs1 high with rs2 low.
- R4: Narrow form (word_mode=0, xlen64=0): the halfwords come from rs1[31:0] and rs2[31:0] ([15:0] low, [31:16] high). result[31:0] = acc[31:0] + (product >>> 15) modulo 2^32, and result[63:32] = 0.
- R5: With rnd=1, 2^14 (halfword operands) or 2^30 (32-bit operands) is added to the product before the shift. With rnd=0, nothing is added.
- R6: Wide form (word_mode=1, either xlen64): the operands are rs1/rs2 [31:0] (low) or [63:32] (high). result = acc + sign-extended (product >>> 31) modulo 2^64.
- R7: Packed form (word_mode=0, xlen64=1): lane i (i=0,1) uses halfword 2i (low) or 2i+1 (high) of each source and writes result[32i+31:32i] = acc[32i+31:32i] + (product_i >>> 15) modulo 2^32. A carry out of lane 0 does not reach lane 1.
- R8: The most negative operand squared is not clamped. It adds +2^15 (halfword) or +2^31 (32-bit) to the accumulator, and the sum wraps if it overflows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Launches an operation this cycle |
| sel | input | 2 | Half-selection code: bit 1 selects the rs1 half, bit 0 selects the rs2 half |
| rnd | input | 1 | Adds the rounding constant before the shift |
| word_mode | input | 1 | 1 = 32-bit operands into a 64-bit accumulator |
| xlen64 | input | 1 | With word_mode=0, 1 = packed two-lane form, 0 = narrow form |
| rs1 | input | 64 | First source word |
| rs2 | input | 64 | Second source word |
| acc | input | 64 | Accumulator input |
| out_valid | output | 1 | Result register holds a fresh result |
| result | output | 64 | Registered accumulate result |

## Verification
The only internal state is the result register and the valid flag. A wrong capture shows at the ports one edge after the launching cycle, either as a bad sum or as a result that changes during an idle cycle. Some faults never touch state: a swapped half select, a missing rounding constant, a lost sign extension, or a carry that leaks between lanes. These show in the first result whose operands exercise the faulty path, so the mix covers every selection code, every form, operands of both signs, the most negative values, and accumulators near the wrap point.

// File: rtl/qmac_unit.sv
module qmac_unit #(
  parameter int HW = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        sel,
  input  logic              rnd,
  input  logic              word_mode,
  input  logic              xlen64,
  input  logic [4*HW-1:0]   rs1,
  input  logic [4*HW-1:0]   rs2,
  input  logic [4*HW-1:0]   acc,
  output logic              out_valid,
  output logic [4*HW-1:0]   result
);
  localparam int WW = 2 * HW;
  localparam int DW = 4 * HW;
  localparam logic [WW:0] HRND = (WW+1)'(1) << (HW - 2);
  localparam logic [DW:0] WRND = (DW+1)'(1) << (WW - 2);

  logic [WW-1:0] lane_sum [2];

  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic signed [HW-1:0] ha, hb;
    logic signed [WW-1:0] hprod;
    logic signed [WW:0]   hsum, hsh;
    assign ha    = sel[1] ? rs1[WW*g+HW +: HW] : rs1[WW*g +: HW];
    assign hb    = sel[0] ? rs2[WW*g+HW +: HW] : rs2[WW*g +: HW];
    assign hprod = WW'(ha) * WW'(hb);
    assign hsum  = {hprod[WW-1], hprod} + (rnd ? HRND : '0);
    assign hsh   = hsum >>> (HW - 1);
    assign lane_sum[g] = acc[WW*g +: WW] + hsh[WW-1:0];
  end

  logic signed [WW-1:0] wa, wb;
  logic signed [DW-1:0] wprod;
  logic signed [DW:0]   wsum, wsh;
  logic [DW-1:0]        word_sum;
  assign wa       = sel[1] ? rs1[DW-1:WW] : rs1[WW-1:0];
  assign wb       = sel[0] ? rs2[DW-1:WW] : rs2[WW-1:0];
  assign wprod    = DW'(wa) * DW'(wb);
  assign wsum     = {wprod[DW-1], wprod} + (rnd ? WRND : '0);
  assign wsh      = wsum >>> (WW - 1);
  assign word_sum = acc + wsh[DW-1:0];

  logic [DW-1:0] next_res;
  always_comb begin
    if (word_mode)   next_res = word_sum;
    else if (xlen64) next_res = {lane_sum[1], lane_sum[0]};
    else             next_res = {{WW{1'b0}}, lane_sum[0]};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_res;
    end
  end
endmodule

// File: rtl/qmac_unit_chk.sv
module qmac_unit_chk #(
  parameter int HW = 16
) (
  input logic            clk,
  input logic            rst_n,
  input logic            in_valid,
  input logic            word_mode,
  input logic            xlen64,
  input logic [4*HW-1:0] rs1,
  input logic [4*HW-1:0] acc,
  input logic            out_valid,
  input logic [4*HW-1:0] result
);
  localparam int WW = 2 * HW;

  p_reset_clear_r1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && result == '0));

  p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);

  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> (!out_valid && $stable(result)));

  p_narrow_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !word_mode && !xlen64) |=> (result[4*HW-1:WW] == '0));

  p_zero_operand_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && rs1 == '0 && (word_mode || xlen64)) |=> (result == $past(acc)));
endmodule

bind qmac_unit qmac_unit_chk #(.HW(HW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .word_mode(word_mode),
  .xlen64(xlen64), .rs1(rs1), .acc(acc), .out_valid(out_valid), .result(result)
);

// File: tb/tb_qmac_unit.sv
`timescale 1ns/1ps
module tb_qmac_unit;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        in_valid = 0;
  logic [1:0]  sel = 0;
  logic        rnd = 0, word_mode = 0, xlen64 = 0;
  logic [63:0] rs1 = 0, rs2 = 0, acc = 0;
  logic        out_valid;
  logic [63:0] result;
  int total = 0, bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  qmac_unit dut (.*);

  function automatic logic [63:0] model(logic [1:0] s, logic r, logic wm, logic x64,
                                        logic [63:0] a1, logic [63:0] a2, logic [63:0] ac);
    logic [63:0] res;
    res = 64'd0;
    if (wm) begin
      longint p, x, y;
      x = longint'($signed(s[1] ? a1[63:32] : a1[31:0]));
      y = longint'($signed(s[0] ? a2[63:32] : a2[31:0]));
      p = x * y + (r ? 64'sd1073741824 : 64'sd0);
      res = ac + 64'(p >>> 31);
    end else begin
      for (int i = 0; i < (x64 ? 2 : 1); i++) begin
        int p, x, y;
        x = int'($signed(a1[32*i + (s[1] ? 16 : 0) +: 16]));
        y = int'($signed(a2[32*i + (s[0] ? 16 : 0) +: 16]));
        p = x * y + (r ? 16384 : 0);
        res[32*i +: 32] = ac[32*i +: 32] + 32'(p >>> 15);
      end
    end
    return res;
  endfunction

  task automatic check(string tag, logic [63:0] got, logic [63:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic run(string tag, logic [1:0] s, logic r, logic wm, logic x64,
                     logic [63:0] a1, logic [63:0] a2, logic [63:0] ac, logic [63:0] exp);
    @(negedge clk);
    in_valid = 1; sel = s; rnd = r; word_mode = wm; xlen64 = x64;
    rs1 = a1; rs2 = a2; acc = ac;
    @(negedge clk);
    in_valid = 0;
    check({tag, " R2 valid"}, {63'd0, out_valid}, 64'd1);
    check(tag, result, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 reset valid", {63'd0, out_valid}, 64'd0);
    check("R1 reset result", result, 64'd0);
    rst_n = 1;

    // R3 selection codes, narrow form: rs1 halves 3 / 5, rs2 halves 7 / 11 (Q15 ints)
    run("R3 sel00", 2'b00, 0, 0, 0, 64'h0005_0003, 64'h000b_0007, 64'd0, 64'd0);
    run("R3 sel00 big", 2'b00, 0, 0, 0, 64'h0000_4000, 64'h1234_4000, 64'd10, 64'd10 + 64'h2000);
    run("R3 sel01", 2'b01, 0, 0, 0, 64'h0000_4000, 64'h2000_0000, 64'd0, 64'h1000);
    run("R3 sel11", 2'b11, 0, 0, 0, 64'hc000_0000, 64'h4000_0000, 64'd0, 64'hffff_e000);
    run("R3 sel10", 2'b10, 0, 0, 0, 64'h4000_0000, 64'h0000_6000, 64'd0, 64'h3000);
    // R5 rounding: 0.5 * 2^-15 -> 0 truncated, 1 rounded
    run("R5 trunc", 2'b00, 0, 0, 0, 64'h4000, 64'h0001, 64'd0, 64'd0);
    run("R5 round", 2'b00, 1, 0, 0, 64'h4000, 64'h0001, 64'd0, 64'd1);
    run("R5 round word", 2'b00, 1, 1, 0, 64'h4000_0000, 64'h1, 64'd0, 64'd1);
    // R4 wrap and upper zero
    run("R4 wrap", 2'b00, 0, 0, 0, 64'hffff_ffff_0000_8000, 64'h8000, 64'hffff_ffff_7fff_ffff, 64'h8000_7fff);
    // R8 most negative squared
    run("R8 half", 2'b11, 0, 0, 0, 64'h8000_0000, 64'h8000_0000, 64'd0, 64'h8000);
    run("R8 word", 2'b00, 0, 1, 0, 64'h8000_0000, 64'h8000_0000, 64'd0, 64'h8000_0000);
    run("R8 word round", 2'b11, 1, 1, 1, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000, 64'h7fff_ffff_8000_0000, 64'h8000_0000_0000_0000);
    // R6 wide form with negative product
    run("R6 neg", 2'b01, 0, 1, 0, 64'h0000_0000_c000_0000, 64'h4000_0000_0000_0000, 64'd0, 64'hffff_ffff_e000_0000);
    // R7 packed: lane 0 wraps to zero, lane 1 unaffected
    run("R7 no carry", 2'b00, 0, 0, 1, 64'h0000_4000_0000_0002, 64'h0000_4000_0000_4000, 64'h0000_0005_ffff_ffff, 64'h0000_2005_0000_0000);
    run("R7 high halves", 2'b11, 0, 0, 1, 64'h2000_0000_4000_0000, 64'h4000_0000_8000_0000, 64'd0, 64'h0000_1000_ffff_c000);

    // R2 idle hold
    held = result;
    @(negedge clk);
    in_valid = 0; rs1 = 64'h1234; rs2 = 64'h5678; acc = 64'h9; word_mode = 1;
    @(negedge clk);
    check("R2 idle valid", {63'd0, out_valid}, 64'd0);
    check("R2 idle hold", result, held);

    for (int n = 0; n < 400; n++) begin
      logic [1:0] s; logic r, wm, x; logic [63:0] a1, a2, ac;
      string tag;
      s = 2'($urandom); r = 1'($urandom); wm = 1'($urandom); x = 1'($urandom);
      a1 = {$urandom, $urandom}; a2 = {$urandom, $urandom}; ac = {$urandom, $urandom};
      if (n % 16 == 0) a1[15:0] = 16'h8000;
      if (n % 16 == 0) a2[15:0] = 16'h8000;
      tag = wm ? "R6 rand" : (x ? "R7 rand" : "R4 rand");
      run(tag, s, r, wm, x, a1, a2, ac, model(s, r, wm, x, a1, a2, ac));
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule